// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a free-running watchdog that software arms through a small register interface. Once it is enabled, an internal counter advances on every clock. Software must write the refresh bit before the count reaches the selected period. The period comes from a power-of-two ladder: a 3-bit scale field multiplies a base tick count by 1, 2, 4 and so on, up to 128.

When the period runs out, the block can raise a system reset request, drive an external watchdog pin, or do both. Each of these is gated by its own enable bit. Each action is a fixed-length pulse. When expiry raises a reset request, a sticky cause flag is also latched. Software can read this flag after restart to learn why the system went down, and clears it by writing a one.

The register interface has two addresses, with a single address line shared by reads and writes:

- Address 0 is control: bit 0 run, bit 1 refresh, bit 2 reset enable, bit 3 pin enable, bits 6:4 scale.
- Address 1 is status: bit 0 is the cause flag.

Top module: `wdog_timer`

## Requirements
- R1: After reset, both registers read zero and neither `rst_req` nor `wdt_out` is asserted.
- R2: With run set, expiry occurs `BASE_TICKS << scale` clock edges after the control write that set run, or after the last refresh, for every scale value 0 to 7.
- R3: Writing control with bit 1 set restarts the count from zero. Bit 1 always reads back as 0, while the other control fields read back as written.
- R4: While run is clear, the counter is held and expiry never occurs, whatever the other fields hold.
- R5: On expiry with reset enable (bit 2) set, `rst_req` goes high in the cycle after the expiring edge and stays high for exactly `RST_PULSE` cycles. With bit 2 clear, `rst_req` stays low.
- R6: On expiry with reset enable set, the cause flag (status bit 0) sets. Writing status with bit 0 = 0 leaves it set, and writing bit 0 = 1 clears it.
- R7: On expiry with pin enable (bit 3) set, `wdt_out` pulses with the same timing and length as R5, independent of bit 2. With bit 3 clear, `wdt_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the register selected by `addr` |
| rst_req | output | 1 | System reset request pulse |
| wdt_out | output | 1 | External watchdog pin pulse |

## Verification
The hardest situation to reach is a refresh that lands just before expiry. A stimulus that is off by one edge either lets the counter expire or tests nothing. The random cases therefore place each refresh at a random distance inside the current period, up to the last edge before expiry. They then measure the exact edge of the following expiry against the scaled period. The largest scale is run once directly, so the top of the ladder is timed too.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int BASE_TICKS = 1600000,
  parameter int RST_PULSE  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       rst_req,
  output logic       wdt_out
);
  localparam int CW  = $clog2(BASE_TICKS) + 8;
  localparam int PCW = $clog2(RST_PULSE + 1);

  logic          en_q, rst_en_q, out_en_q, flag_q, pr_q, po_q;
  logic [2:0]    psc_q;
  logic [CW-1:0] cnt_q, limit;
  logic [PCW-1:0] pcnt_q;

  wire ctrl_wr = wr_en && !addr;
  wire stat_wr = wr_en && addr;
  wire kick    = ctrl_wr && wr_data[1];

  assign limit = CW'(BASE_TICKS) << psc_q;
  wire expire  = en_q && !kick && (cnt_q >= limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rst_en_q <= 1'b0;
      out_en_q <= 1'b0;
      psc_q    <= '0;
    end else if (ctrl_wr) begin
      en_q     <= wr_data[0];
      rst_en_q <= wr_data[2];
      out_en_q <= wr_data[3];
      psc_q    <= wr_data[6:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!en_q || kick || expire) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      pr_q   <= 1'b0;
      po_q   <= 1'b0;
    end else if (expire && (rst_en_q || out_en_q)) begin
      pcnt_q <= PCW'(RST_PULSE);
      pr_q   <= rst_en_q;
      po_q   <= out_en_q;
    end else if (pcnt_q != '0) begin
      pcnt_q <= pcnt_q - PCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       flag_q <= 1'b0;
    else if (expire && rst_en_q)      flag_q <= 1'b1;
    else if (stat_wr && wr_data[0])   flag_q <= 1'b0;
  end

  assign rst_req = pr_q && (pcnt_q != '0);
  assign wdt_out = po_q && (pcnt_q != '0);
  assign rd_data = addr ? {7'b0, flag_q}
                        : {1'b0, psc_q, out_en_q, rst_en_q, 1'b0, en_q};
endmodule

module wdog_timer_chk #(
  parameter int RST_PULSE = 32,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          addr,
  input logic [7:0]    wr_data,
  input logic          rst_req,
  input logic          wdt_out,
  input logic          en_q,
  input logic          flag_q,
  input logic [CW-1:0] cnt_q
);
  int unsigned run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= 0;
    else if (rst_req) run_len <= run_len + 1;
    else              run_len <= 0;
  end

  // R3
  refresh_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wr_data[1]) |=> (cnt_q == '0));
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (!$rose(rst_req) && !$rose(wdt_out)));
  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (run_len >= RST_PULSE));
  // R6
  cause_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> flag_q);
  // R6
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_en && addr && wr_data[0])) |=> flag_q);
endmodule

bind wdog_timer wdog_timer_chk #(.RST_PULSE(RST_PULSE), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rst_req(rst_req), .wdt_out(wdt_out), .en_q(en_q), .flag_q(flag_q),
  .cnt_q(cnt_q)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  localparam int BASE  = 40;
  localparam int PULSE = 32;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rst_req, wdt_out;
  int checks = 0, fails = 0;

  wdog_timer #(.BASE_TICKS(BASE), .RST_PULSE(PULSE)) i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rst_req(rst_req), .wdt_out(wdt_out));

  always #2.5 clk = ~clk;

  function automatic int period(int p);
    return BASE << p;
  endfunction

  function automatic logic [7:0] ctrl(int p, bit re, bit oe, bit run, bit kick);
    return {1'b0, 3'(p), oe, re, kick, run};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(bit a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic run_case(int p, bit re, bit oe, int kicks);
    int first_r = 0, first_o = 0, len_r = 0, len_o = 0;
    logic [7:0] d;
    wr(1'b1, 8'h01);
    wr(1'b0, ctrl(p, re, oe, 1'b1, 1'b0));
    for (int k = 0; k < kicks; k++) begin
      int dly = $urandom_range(period(p) - 2, 1);
      for (int c = 0; c < dly; c++) begin @(posedge clk); @(negedge clk); end
      wr(1'b0, ctrl(p, re, oe, 1'b1, 1'b1));
    end
    for (int n = 1; n <= period(p) + PULSE + 4; n++) begin
      @(posedge clk); @(negedge clk);
      if (rst_req && first_r == 0) first_r = n;
      if (wdt_out && first_o == 0) first_o = n;
      if (rst_req) len_r++;
      if (wdt_out) len_o++;
    end
    // R2 R5: timing of reset request after last start/refresh
    chk(first_r == (re ? period(p) : 0), "R2/R5 req edge", first_r, re ? period(p) : 0);
    chk(len_r == (re ? PULSE : 0), "R5 req length", len_r, re ? PULSE : 0);
    // R7
    chk(first_o == (oe ? period(p) : 0), "R7 pin edge", first_o, oe ? period(p) : 0);
    chk(len_o == (oe ? PULSE : 0), "R7 pin length", len_o, oe ? PULSE : 0);
    rd(1'b1, d);
    chk(d[0] == re, "R6 cause flag", d[0], re);
    wr(1'b0, 8'h00);
    if (re) begin
      wr(1'b1, 8'h00);
      rd(1'b1, d);
      chk(d[0] == 1'b1, "R6 write zero keeps flag", d[0], 1);
      wr(1'b1, 8'h01);
      rd(1'b1, d);
      chk(d[0] == 1'b0, "R6 write one clears flag", d[0], 0);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, d); chk(d == 8'h00, "R1 control reset", d, 0);
    rd(1'b1, d); chk(d == 8'h00, "R1 status reset", d, 0);
    chk(!rst_req && !wdt_out, "R1 outputs reset", {rst_req, wdt_out}, 0);

    // R3 refresh bit readback
    wr(1'b0, ctrl(5, 1'b0, 1'b1, 1'b0, 1'b1));
    rd(1'b0, d); chk(d == 8'h58, "R3 refresh reads zero", d, 8'h58);

    // R4 run clear: nothing happens
    wr(1'b0, ctrl(0, 1'b1, 1'b1, 1'b0, 1'b0));
    seen = 0;
    for (int n = 0; n < 3 * BASE; n++) begin
      @(posedge clk); @(negedge clk);
      if (rst_req || wdt_out) seen++;
    end
    chk(seen == 0, "R4 no expiry while stopped", seen, 0);
    rd(1'b1, d); chk(d[0] == 1'b0, "R4 flag untouched", d[0], 0);
    wr(1'b0, 8'h00);

    run_case(0, 1'b1, 1'b0, 0);
    run_case(0, 1'b0, 1'b1, 0);
    run_case(0, 1'b0, 1'b0, 0);
    run_case(7, 1'b1, 1'b1, 0);
    run_case(1, 1'b1, 1'b1, 3);

    for (int i = 0; i < 10; i++)
      run_case($urandom_range(3, 0), 1'($urandom), 1'($urandom), $urandom_range(3, 0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule